// File: doc/BRIEF.md
# SPI Hold Pause Controller

This block sits between the pins of an SPI slave and its shift engine and implements the pause function driven by an active-low hold input. It samples chip select, the serial clock and the hold input in the system clock domain. From them it derives one-cycle strobes for the rising and falling edges of the serial clock, and it qualifies those strobes against selection and pause state. The shift engine therefore only advances while the bus is selected and not paused.

A pause request takes effect only while the serial clock is low. A request that arrives while the clock is high waits for the clock's next low phase, and a release does the same. While paused, the block blocks both edge strobes and forces the masked data input to zero. It keeps the position within the current byte and holds the data-output enable off. After the pause ends, the output enable stays off until the first qualified falling edge of the serial clock. Deselecting the device during a pause clears the pause and the byte position, and it raises a one-cycle abort strobe so the shift engine can drop any partly received instruction.

Top module: `hold_ctrl`

## Requirements
- R1: After reset with chip select high, hold_o, q_oe_o, abort_o and both edge strobes are 0 and bit_pos_o is 0.
- R2: With cs_ni low, a clock edge of clk_i that samples sck_i low and hold_ni low sets hold_o to 1 from that edge on.
- R3: While sck_i is high, hold_o does not go from 0 to 1 even if hold_ni is low. Entry happens at the first clk_i edge that samples sck_i low.
- R4: With hold_o at 1, a clk_i edge that samples sck_i low and hold_ni high clears hold_o. A release seen while sck_i is high leaves hold_o at 1 until sck_i is sampled low.
- R5: While hold_o is 1, sck_rise_en_o, sck_fall_en_o and sdi_o are 0, and bit_pos_o keeps its value, whatever sck_i and sdi_i do.
- R6: q_oe_o is 0 while hold_o is 1. After hold_o returns to 0, q_oe_o stays 0 until the clk_i edge that ends the cycle in which sck_fall_en_o was 1, and it is 1 from then on.
- R7: When cs_ni is sampled high, hold_o is 0 from the next clk_i edge. abort_o is 1 in exactly the cycle where cs_ni has just risen while hold_o is 1.
- R8: While cs_ni is high, hold_ni has no effect: hold_o stays 0.
- R9: bit_pos_o counts sck_rise_en_o pulses modulo BYTE_W, with a default of 8 so the range is 0 to 7. It is cleared at any clk_i edge that samples cs_ni high.
- R10: sck_rise_en_o is 1 for exactly one clk_i cycle per low-to-high change of sck_i, and sck_fall_en_o is 1 for exactly one cycle per high-to-low change, both only while selected and not held.

Ports

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the SPI pins |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low, synchronous to clk_i |
| sck_i | input | 1 | Serial clock level, synchronous to clk_i |
| hold_ni | input | 1 | Pause request, active low |
| sdi_i | input | 1 | Serial data in from the pin |
| hold_o | output | 1 | Pause active |
| sck_rise_en_o | output | 1 | Qualified rising-edge strobe for the shift engine |
| sck_fall_en_o | output | 1 | Qualified falling-edge strobe for the shift engine |
| sdi_o | output | 1 | Serial data in, masked while deselected or paused |
| q_oe_o | output | 1 | Output-enable override for serial data out |
| abort_o | output | 1 | One-cycle strobe when deselected during a pause |
| bit_pos_o | output | 3 | Bit position within the current byte |

## Verification
The assertions assume that cs_ni, sck_i, hold_ni and sdi_i are already synchronous to clk_i and that each level lasts at least one clk_i cycle, so every serial clock phase is seen by at least one sample. The stimulus changes inputs only shortly after a rising edge of clk_i and holds each level for at least one full cycle. It sweeps hold entry at every byte position. For each position it covers entry with the serial clock high and low, and exit with the serial clock high and low.

// File: rtl/hold_pkg.sv
package hold_pkg;
  typedef struct packed {
    logic rise;
    logic fall;
  } edge_t;
endpackage

// File: rtl/hold_edge_det.sv
module hold_edge_det #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            sig_i,
  output hold_pkg::edge_t edge_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= RST_VAL;
    else         prev_q <= sig_i;
  end

  assign edge_o.rise = sig_i & ~prev_q;
  assign edge_o.fall = ~sig_i & prev_q;
endmodule

// File: rtl/hold_state.sv
module hold_state (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cs_ni,
  input  logic sck_i,
  input  logic hold_ni,
  input  logic fall_qual_i,
  output logic hold_o,
  output logic oe_blk_o
);
  logic hold_q, blk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      blk_q  <= 1'b0;
    end else if (cs_ni) begin
      hold_q <= 1'b0;
      blk_q  <= 1'b0;
    end else begin
      // pause state only moves in the low phase of the serial clock
      if (!sck_i) hold_q <= ~hold_ni;
      if (hold_q)           blk_q <= 1'b1;
      else if (fall_qual_i) blk_q <= 1'b0;
    end
  end

  assign hold_o   = hold_q;
  assign oe_blk_o = blk_q;
endmodule

// File: rtl/hold_bit_track.sv
module hold_bit_track #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             step_i,
  output logic [CNT_W-1:0] pos_o
);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);
  logic [CNT_W-1:0] pos_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '0;
    else if (clr_i)  pos_q <= '0;
    else if (step_i) pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
  end

  assign pos_o = pos_q;
endmodule

// File: rtl/hold_ctrl.sv
module hold_ctrl #(
  parameter int BYTE_W = 8,
  localparam int CNT_W = (BYTE_W > 1) ? $clog2(BYTE_W) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_ni,
  input  logic             sck_i,
  input  logic             hold_ni,
  input  logic             sdi_i,
  output logic             hold_o,
  output logic             sck_rise_en_o,
  output logic             sck_fall_en_o,
  output logic             sdi_o,
  output logic             q_oe_o,
  output logic             abort_o,
  output logic [CNT_W-1:0] bit_pos_o
);
  hold_pkg::edge_t sck_edge;
  logic hold_q, oe_blk, run, cs_prev_q;

  hold_edge_det #(.RST_VAL(1'b0)) u_sck_edge (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .sig_i  (sck_i),
    .edge_o (sck_edge)
  );

  assign run           = ~cs_ni & ~hold_q;
  assign sck_rise_en_o = sck_edge.rise & run;
  assign sck_fall_en_o = sck_edge.fall & run;
  assign sdi_o         = sdi_i & run;

  hold_state u_state (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .cs_ni       (cs_ni),
    .sck_i       (sck_i),
    .hold_ni     (hold_ni),
    .fall_qual_i (sck_fall_en_o),
    .hold_o      (hold_q),
    .oe_blk_o    (oe_blk)
  );

  hold_bit_track #(.BYTE_W(BYTE_W)) u_bits (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (cs_ni),
    .step_i (sck_rise_en_o),
    .pos_o  (bit_pos_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cs_prev_q <= 1'b1;
    else         cs_prev_q <= cs_ni;
  end

  assign hold_o  = hold_q;
  assign q_oe_o  = run & ~oe_blk;
  assign abort_o = cs_ni & ~cs_prev_q & hold_q;
endmodule

// File: rtl/hold_ctrl_chk.sv
module hold_ctrl_chk #(
  parameter int CNT_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_ni,
  input logic             sck_i,
  input logic             hold_ni,
  input logic             hold_o,
  input logic             sck_rise_en_o,
  input logic             sck_fall_en_o,
  input logic             sdi_o,
  input logic             q_oe_o,
  input logic [CNT_W-1:0] bit_pos_o
);
  a_r2_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !sck_i && !hold_ni) |=> hold_o);
  a_r3_no_entry_sck_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hold_o && sck_i) |=> !hold_o);
  a_r4_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !sck_i && hold_ni) |=> !hold_o);
  a_r4_defer_exit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !cs_ni && sck_i) |=> hold_o);
  a_r5_no_strobes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> (!sck_rise_en_o && !sck_fall_en_o && !sdi_o));
  a_r5_pos_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hold_o && !cs_ni) |=> $stable(bit_pos_o));
  a_r6_oe_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_o |-> !q_oe_o);
  a_r7_r8_desel_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> !hold_o);
  a_r9_pos_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_ni |=> (bit_pos_o == '0));
  a_r10_single_rise: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_rise_en_o |=> !sck_rise_en_o);
  a_r10_single_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sck_fall_en_o |=> !sck_fall_en_o);
endmodule

bind hold_ctrl hold_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .cs_ni         (cs_ni),
  .sck_i         (sck_i),
  .hold_ni       (hold_ni),
  .hold_o        (hold_o),
  .sck_rise_en_o (sck_rise_en_o),
  .sck_fall_en_o (sck_fall_en_o),
  .sdi_o         (sdi_o),
  .q_oe_o        (q_oe_o),
  .bit_pos_o     (bit_pos_o)
);

// File: tb/hold_ctrl_bench.sv
`timescale 1ns/1ps
module hold_ctrl_bench;
  localparam int BW = 8;

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic cs_ni = 1'b1, sck_i = 1'b0, hold_ni = 1'b1, sdi_i = 1'b0;
  logic hold_o, sck_rise_en_o, sck_fall_en_o, sdi_o, q_oe_o, abort_o;
  logic [2:0] bit_pos_o;
  int checks = 0, failures = 0;

  always #4 clk_i = ~clk_i;

  hold_ctrl #(.BYTE_W(BW)) u_hold_ctrl (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    #2;
  endtask

  // one full serial clock period, rise counted by the shift engine
  task automatic sck_pulse();
    sck_i = 1'b1; #1;
    check("R10 rise strobe", sck_rise_en_o, 1);
    tick();
    check("R10 rise width", sck_rise_en_o, 0);
    sck_i = 1'b0; #1;
    check("R10 fall strobe", sck_fall_en_o, 1);
    tick();
  endtask

  task automatic scenario(input int k, input bit entry_hi, input bit exit_hi);
    int cnt;
    cs_ni = 1'b0; tick();
    check("R9 start pos", bit_pos_o, 0);
    for (int i = 0; i < k; i++) sck_pulse();
    cnt = k;
    if (entry_hi) begin
      sck_i = 1'b1; tick(); cnt++;
      hold_ni = 1'b0; tick();
      check("R3 deferred entry", hold_o, 0);
      sck_i = 1'b0; tick();
      check("R3 entry on low", hold_o, 1);
    end else begin
      hold_ni = 1'b0; tick();
      check("R2 entry", hold_o, 1);
    end
    for (int i = 0; i < 3; i++) begin
      sck_i = 1'b1; sdi_i = 1'b1; #1;
      check("R5 rise masked", sck_rise_en_o, 0);
      check("R5 sdi masked", sdi_o, 0);
      tick();
      sck_i = 1'b0; #1;
      check("R5 fall masked", sck_fall_en_o, 0);
      tick();
      check("R5 pos kept", bit_pos_o, cnt % BW);
      check("R6 oe off in hold", q_oe_o, 0);
    end
    sdi_i = 1'b0;
    if (exit_hi) begin
      sck_i = 1'b1; tick();
      hold_ni = 1'b1; tick();
      check("R4 deferred exit", hold_o, 1);
      sck_i = 1'b0; tick();
      check("R4 exit on low", hold_o, 0);
    end else begin
      hold_ni = 1'b1; tick();
      check("R4 exit", hold_o, 0);
    end
    check("R6 oe still off", q_oe_o, 0);
    check("R5 pos after hold", bit_pos_o, cnt % BW);
    sck_i = 1'b1; tick();
    cnt++;
    check("R6 oe off before fall", q_oe_o, 0);
    sck_i = 1'b0; #1;
    check("R6 fall strobe", sck_fall_en_o, 1);
    tick();
    check("R6 oe back", q_oe_o, 1);
    check("R9 pos count", bit_pos_o, cnt % BW);
    cs_ni = 1'b1; tick();
    check("R9 cleared", bit_pos_o, 0);
  endtask

  initial begin
    #(8 * 200000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #20 rst_ni = 1'b1;
    tick();
    check("R1 hold", hold_o, 0);
    check("R1 oe", q_oe_o, 0);
    check("R1 abort", abort_o, 0);
    check("R1 pos", bit_pos_o, 0);
    check("R1 rise", sck_rise_en_o, 0);

    hold_ni = 1'b0; tick(); tick();
    check("R8 no hold deselected", hold_o, 0);
    hold_ni = 1'b1; tick();

    for (int k = 0; k < BW; k++)
      for (int e = 0; e < 2; e++)
        for (int x = 0; x < 2; x++)
          scenario(k, e[0], x[0]);

    // deselect during hold
    cs_ni = 1'b0; tick();
    sck_pulse(); sck_pulse(); sck_pulse();
    hold_ni = 1'b0; tick();
    check("R7 in hold", hold_o, 1);
    cs_ni = 1'b1; #1;
    check("R7 abort pulse", abort_o, 1);
    tick();
    check("R7 hold cleared", hold_o, 0);
    check("R7 abort width", abort_o, 0);
    check("R7 pos reset", bit_pos_o, 0);
    tick();
    check("R8 held low ignored", hold_o, 0);
    hold_ni = 1'b1;
    cs_ni = 1'b0; tick();
    check("R7 fresh select oe", q_oe_o, 1);
    sck_pulse();
    check("R9 restart pos", bit_pos_o, 1);
    cs_ni = 1'b1; #1;
    check("R7 no abort outside hold", abort_o, 0);
    tick();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule